// File: doc/BRIEF.md
# Parallel Image Sensor Capture

This block receives pixel bytes from a camera-style parallel port clocked by a free-running pixel clock, with a frame-valid and a line-valid qualifier. It keeps only the bytes seen while both qualifiers are high and packs each group of four into a 32-bit word, lowest byte first. It sends the words out as a valid/ready stream. Each word is tagged with the buffer channel (0 or 1) it belongs to. The last word of every buffer carries an end-of-buffer marker and the byte count of that buffer.

Capture alternates between two buffer channels: one fills while the consumer drains the other. A buffer closes when it reaches `BUF_BYTES` bytes. It also closes early, as a short buffer, when the frame ends. In that case any partly assembled word is padded with zeros. After a buffer closes, its channel stays claimed until the consumer hands it back with a release pulse. If capture needs a channel that is still claimed, the bytes are dropped and a sticky overflow flag is raised. The block also drives an active-low reset line to the sensor, which follows a host request bit.

Top module: `pixcap_top`

## Requirements
- R1: A byte on `pix_i` is taken at a rising clock edge only when `fv_i` and `lv_i` are both high at that edge. Bytes during line blanking (`lv_i` low) are ignored, and so are bytes outside the frame (`fv_i` low).
- R2: Accepted bytes are packed little-endian. The first byte of a word goes in `out_data_o[7:0]` and the fourth in `out_data_o[31:24]`. Packing continues across line boundaries within a frame.
- R3: A buffer closes when its count reaches `BUF_BYTES`, a multiple of 4 (default 16). Its final word has `out_last_o`=1 and `out_bytes_o`=`BUF_BYTES`. `buf_full_o` pulses high for one cycle, the cycle after the edge that took the final byte.
- R4: After reset, the first buffer uses channel 0 (`out_chan_o`=0). Every closed buffer switches capture to the other channel, so buffers alternate 0, 1, 0, ...
- R5: At the first edge with `fv_i` low after a frame, the current buffer closes early if it holds any bytes. A partly packed word is emitted with its unused upper bytes set to zero. The final word carries `out_last_o`=1 and `out_bytes_o` equal to the buffer's byte count, including when that count is a multiple of 4. `frame_done_o` pulses for one cycle after that edge.
- R6: A frame that ends with zero bytes in the current buffer emits no extra word and does not switch channel, but `frame_done_o` still pulses.
- R7: Once a buffer closes, its channel is claimed until `release_i[ch]` pulses. A byte that arrives while the current channel is claimed is dropped and sets `overflow_o`. The flag stays set until reset. Capture resumes into the channel once it is released.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` and all output word fields hold their values.
- R9: `sens_rst_n_o` is driven low during reset. Otherwise it equals the inverse of `sens_rst_req_i` sampled one clock earlier.
- R10: During reset, `out_valid_o`, `overflow_o`, `buf_full_o` and `frame_done_o` are low, and both channels are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| sens_rst_req_i | input | 1 | Host request to hold the sensor in reset |
| fv_i | input | 1 | Frame-valid qualifier |
| lv_i | input | 1 | Line-valid qualifier |
| pix_i | input | 8 | Sensor pixel byte |
| release_i | input | 2 | Per-channel release pulse from the consumer |
| out_ready_i | input | 1 | Stream ready from the consumer |
| out_valid_o | output | 1 | Stream word valid |
| out_data_o | output | 32 | Packed word, first byte in bits 7:0 |
| out_chan_o | output | 1 | Buffer channel of the word |
| out_last_o | output | 1 | Final word of a buffer |
| out_bytes_o | output | 16 | Byte count of the buffer, meaningful with out_last_o |
| buf_full_o | output | 1 | One-cycle pulse when a buffer fills |
| frame_done_o | output | 1 | One-cycle pulse at frame end |
| overflow_o | output | 1 | Sticky flag for bytes lost to a claimed channel or a full queue |
| sens_rst_n_o | output | 1 | Active-low reset to the sensor |

## Verification
A wrong lane index or a stale shift register shows up at the ports as misplaced or non-zero padding bytes in the very next word of the stream. A wrong byte counter or channel bit shows up as an end-of-buffer marker on the wrong word, a wrong count, or a repeated channel tag. These errors appear within one buffer, at most `BUF_BYTES` accepted bytes later. A channel whose claim is set or cleared wrongly shows up as an unexpected overflow flag or as missing words, as soon as capture wraps back to that channel. The bench therefore compares every word with a model built from the requirements, counts the event pulses, and exercises blanking, aligned and unaligned frame ends, stalls and unreleased channels.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

  // One entry of the outgoing word stream.
  typedef struct packed {
    logic [31:0] data;
    logic        chan;
    logic        last;
    logic [15:0] nbytes;
  } cap_word_t;

  // Zero-pad a partly assembled word. acc holds the newest byte in its top
  // lane; 'fill' bytes are valid and sit in the upper part of acc.
  function automatic logic [31:0] pad_partial(input logic [23:0] acc,
                                              input logic [1:0]  fill);
    return {8'h00, acc} >> (8 * (3 - fill));
  endfunction

endpackage

// File: rtl/pixcap_packer.sv
module pixcap_packer
  import pixcap_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 16
) (
  input  logic      clk_i,
  input  logic      rst_i,
  input  logic      fv_i,
  input  logic      lv_i,
  input  logic [7:0] pix_i,
  input  logic [1:0] free_i,
  output logic      push_o,
  output cap_word_t push_word_o,
  output logic      commit_o,
  output logic      commit_chan_o,
  output logic      drop_o,
  output logic      full_pulse_o,
  output logic      frame_done_o
);

  localparam int unsigned CNT_W = $clog2(BUF_BYTES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BUF_BYTES - 1);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic             fv_q;
  logic [1:0]       lane;
  logic [23:0]      acc;
  logic [CNT_W-1:0] cnt;
  logic             cur;
  cap_word_t        hold;
  logic             hold_v;

  logic take, accept, fv_fall, word_done, flush, full_hit, end_commit, commit;
  logic [31:0] nw_data;
  logic [15:0] nw_bytes;

  always_comb begin
    take       = fv_i & lv_i;
    accept     = take & free_i[cur];
    drop_o     = take & ~free_i[cur];
    fv_fall    = fv_q & ~fv_i;
    word_done  = accept & (lane == 2'd3);
    flush      = fv_fall & (lane != 2'd0);
    full_hit   = accept & (cnt == LAST_CNT);
    end_commit = fv_fall & (cnt != '0);
    commit     = full_hit | end_commit;
    nw_data    = word_done ? {pix_i, acc} : pad_partial(acc, lane);
    nw_bytes   = word_done ? 16'(cnt + ONE_CNT) : 16'(cnt);
  end

  // The held word leaves when a newer word replaces it or when it closes a buffer.
  assign push_o        = hold_v & (hold.last | word_done | flush);
  assign push_word_o   = hold;
  assign commit_o      = commit;
  assign commit_chan_o = cur;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fv_q         <= 1'b0;
      lane         <= 2'd0;
      acc          <= '0;
      cnt          <= '0;
      cur          <= 1'b0;
      hold         <= '0;
      hold_v       <= 1'b0;
      full_pulse_o <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      fv_q         <= fv_i;
      full_pulse_o <= full_hit;
      frame_done_o <= fv_fall;
      if (accept) acc <= {pix_i, acc[23:8]};
      if (fv_fall)     lane <= 2'd0;
      else if (accept) lane <= lane + 2'd1;
      if (commit)      cnt <= '0;
      else if (accept) cnt <= cnt + ONE_CNT;
      if (commit) cur <= ~cur;
      if (word_done | flush) begin
        hold   <= '{data: nw_data, chan: cur, last: commit, nbytes: nw_bytes};
        hold_v <= 1'b1;
      end else if (end_commit) begin
        hold.last   <= 1'b1;
        hold.nbytes <= 16'(cnt);
      end else if (push_o) begin
        hold_v <= 1'b0;
      end
    end
  end

  // R1: nothing is counted in cycles without both qualifiers
  a_r1_blank_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
    !(fv_i && lv_i) |=> (cnt == '0 || $stable(cnt)));
  // R4: every close switches channel
  a_r4_alternate: assert property (@(posedge clk_i) disable iff (rst_i)
    commit |=> cur != $past(cur));
  // R5: frame end leaves no partial state behind
  a_r5_frame_clear: assert property (@(posedge clk_i) disable iff (rst_i)
    fv_fall |=> (lane == 2'd0 && cnt == '0));
  // R3: the count never passes the buffer size
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt <= LAST_CNT);

endmodule

// File: rtl/pixcap_pingpong.sv
module pixcap_pingpong #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              commit_i,
  input  logic              commit_chan_i,
  input  logic [NUM_CH-1:0] release_i,
  output logic [NUM_CH-1:0] free_o
);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    always_ff @(posedge clk_i) begin
      if (rst_i)                                  free_o[k] <= 1'b1;
      else if (commit_i && (commit_chan_i == k))  free_o[k] <= 1'b0;
      else if (release_i[k])                      free_o[k] <= 1'b1;
    end
  end

  // R7: only a free channel is ever closed
  a_r7_close_free: assert property (@(posedge clk_i) disable iff (rst_i)
    commit_i |-> free_o[commit_chan_i]);
  // R7: a closed channel is claimed afterwards
  a_r7_claimed: assert property (@(posedge clk_i) disable iff (rst_i)
    commit_i |=> !free_o[$past(commit_chan_i)]);

endmodule

// File: rtl/pixcap_fifo.sv
module pixcap_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 50
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] dout_o
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          wr_en, rd_en;

  assign full_o = (count == (AW+1)'(DEPTH));
  assign wr_en  = wr_i & ~full_o;
  assign rd_en  = (count != '0) & (~out_valid_o | out_ready_i);

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i) begin
    if (rd_en) dout_o <= mem[rd_ptr];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      out_valid_o <= 1'b0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
      if (rd_en)            out_valid_o <= 1'b1;
      else if (out_ready_i) out_valid_o <= 1'b0;
    end
  end

  // R8: a stalled word stays put
  a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(dout_o)));

endmodule

// File: rtl/pixcap_top.sv
module pixcap_top
  import pixcap_pkg::*;
#(
  parameter int unsigned BUF_BYTES  = 16,
  parameter int unsigned FIFO_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        sens_rst_req_i,
  input  logic        fv_i,
  input  logic        lv_i,
  input  logic [7:0]  pix_i,
  input  logic [1:0]  release_i,
  input  logic        out_ready_i,
  output logic        out_valid_o,
  output logic [31:0] out_data_o,
  output logic        out_chan_o,
  output logic        out_last_o,
  output logic [15:0] out_bytes_o,
  output logic        buf_full_o,
  output logic        frame_done_o,
  output logic        overflow_o,
  output logic        sens_rst_n_o
);

  localparam int unsigned WORD_W = $bits(cap_word_t);

  logic      push, commit, commit_chan, drop, fifo_full;
  logic [1:0] free;
  cap_word_t push_word, head;

  pixcap_packer #(.BUF_BYTES(BUF_BYTES)) packer_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .fv_i          (fv_i),
    .lv_i          (lv_i),
    .pix_i         (pix_i),
    .free_i        (free),
    .push_o        (push),
    .push_word_o   (push_word),
    .commit_o      (commit),
    .commit_chan_o (commit_chan),
    .drop_o        (drop),
    .full_pulse_o  (buf_full_o),
    .frame_done_o  (frame_done_o)
  );

  pixcap_pingpong #(.NUM_CH(2)) pingpong_i (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .commit_i      (commit),
    .commit_chan_i (commit_chan),
    .release_i     (release_i),
    .free_o        (free)
  );

  pixcap_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) fifo_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_i        (push),
    .din_i       (push_word),
    .full_o      (fifo_full),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .dout_o      (head)
  );

  assign out_data_o  = head.data;
  assign out_chan_o  = head.chan;
  assign out_last_o  = head.last;
  assign out_bytes_o = head.nbytes;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      overflow_o   <= 1'b0;
      sens_rst_n_o <= 1'b0;
    end else begin
      overflow_o   <= overflow_o | drop | (push & fifo_full);
      sens_rst_n_o <= ~sens_rst_req_i;
    end
  end

  // R7: overflow is sticky
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    overflow_o |=> overflow_o);
  // R9: sensor reset follows the host request one cycle later
  a_r9_sensor_reset: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (sens_rst_n_o == !$past(sens_rst_req_i)));
  // R3: a closing word carries a sane byte count
  a_r3_last_count: assert property (@(posedge clk_i) disable iff (rst_i)
    (out_valid_o && out_last_o) |-> (out_bytes_o != 16'd0 && out_bytes_o <= 16'(BUF_BYTES)));

endmodule

// File: tb/pixcap_top_tb_top.sv
`timescale 1ns/1ps
module pixcap_top_tb_top;

  localparam int BUF = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, fv = 1'b0, lv = 1'b0, ready = 1'b1;
  logic [7:0]  pix = 8'h00;
  logic [1:0]  rel_auto = 2'b00, rel_man = 2'b00;
  logic        ovalid, ochan, olast, bfull, fdone, ovf, srst_n;
  logic [31:0] odata;
  logic [15:0] obytes;

  always #2.5 clk = ~clk;

  pixcap_top #(.BUF_BYTES(BUF), .FIFO_DEPTH(8)) dut_i (
    .clk_i(clk), .rst_i(rst), .sens_rst_req_i(req), .fv_i(fv), .lv_i(lv),
    .pix_i(pix), .release_i(rel_auto | rel_man), .out_ready_i(ready),
    .out_valid_o(ovalid), .out_data_o(odata), .out_chan_o(ochan),
    .out_last_o(olast), .out_bytes_o(obytes), .buf_full_o(bfull),
    .frame_done_o(fdone), .overflow_o(ovf), .sens_rst_n_o(srst_n));

  typedef struct { logic [31:0] d; logic ch; logic last; int nb; } w_t;
  w_t exp_q[$];
  w_t got_q[$];

  int n_checks = 0, n_fail = 0;
  int n_fd = 0, n_bf = 0, stall_err = 0;
  bit auto_rel = 1;

  // bench model state, from the requirements
  int m_lane, m_cnt;
  logic m_cur;
  logic [31:0] m_acc;
  bit m_free [2];
  bit m_ovf;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, expv);
    end
  endtask

  // monitor: sample away from the active edge
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data;
  always @(negedge clk) begin
    rel_auto <= 2'b00;
    if (!rst) begin
      if (prev_stall && (!ovalid || odata !== prev_data)) stall_err++;
      prev_stall = ovalid && !ready;
      prev_data  = odata;
      if (ovalid && ready) begin
        got_q.push_back('{odata, ochan, olast, int'(obytes)});
        if (olast && auto_rel) rel_auto[ochan] <= 1'b1;
      end
      if (fdone) n_fd++;
      if (bfull) n_bf++;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic m_commit();
    if (!auto_rel) m_free[m_cur] = 0;
    m_cur = ~m_cur;
    m_cnt = 0;
  endtask

  task automatic m_byte(input logic [7:0] b);
    if (!m_free[m_cur]) begin m_ovf = 1; return; end
    m_acc[8*m_lane +: 8] = b;
    m_lane++;
    m_cnt++;
    if (m_lane == 4) begin
      exp_q.push_back('{m_acc, m_cur, (m_cnt == BUF), m_cnt});
      m_acc = '0;
      m_lane = 0;
    end
    if (m_cnt == BUF) m_commit();
  endtask

  task automatic m_frame_end();
    if (m_lane != 0) begin
      exp_q.push_back('{m_acc, m_cur, 1'b1, m_cnt});
      m_acc = '0;
      m_lane = 0;
    end else if (m_cnt != 0) begin
      exp_q[exp_q.size()-1].last = 1'b1;
      exp_q[exp_q.size()-1].nb   = m_cnt;
    end
    if (m_cnt != 0) m_commit();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fv = 0; lv = 0; ready = 1; rel_man = 2'b00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); got_q.delete();
    m_lane = 0; m_cnt = 0; m_cur = 0; m_acc = '0;
    m_free[0] = 1; m_free[1] = 1; m_ovf = 0;
    n_fd = 0; n_bf = 0; stall_err = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    fv = 1; lv = 1; pix = b;
    m_byte(b);
  endtask

  task automatic send_line(input int n, input int seed);
    for (int i = 0; i < n; i++) send_byte(8'(seed + 7*i));
  endtask

  task automatic hblank(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lv = 0; pix = 8'hEE;   // junk that must be ignored
    end
  endtask

  task automatic end_frame();
    @(negedge clk);
    fv = 0; lv = 0; pix = 8'h5A;
    m_frame_end();
    repeat (3) @(negedge clk);
  endtask

  task automatic compare_stream(input string req_tag);
    repeat (20) @(negedge clk);
    check(got_q.size() == exp_q.size(), req_tag, "word count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
      check(got_q[i].d == exp_q[i].d, req_tag, $sformatf("data[%0d]", i), got_q[i].d, exp_q[i].d);
      check(got_q[i].ch == exp_q[i].ch, req_tag, $sformatf("chan[%0d]", i), got_q[i].ch, exp_q[i].ch);
      check(got_q[i].last == exp_q[i].last, req_tag, $sformatf("last[%0d]", i), got_q[i].last, exp_q[i].last);
      if (exp_q[i].last)
        check(got_q[i].nb == exp_q[i].nb, req_tag, $sformatf("bytes[%0d]", i), got_q[i].nb, exp_q[i].nb);
    end
  endtask

  // R10: reset state
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(ovalid == 0, "R10", "out_valid in reset", ovalid, 0);
    check(ovf == 0, "R10", "overflow in reset", ovf, 0);
    check(srst_n == 0, "R9", "sensor reset low in reset", srst_n, 0);
    check(bfull == 0 && fdone == 0, "R10", "pulses in reset", {bfull, fdone}, 0);
  endtask

  // R1, R2, R5: qualifier gating, packing order, unaligned short buffer
  task automatic t_short_frame();
    do_reset();
    for (int i = 0; i < 3; i++) begin   // lv high but fv low: ignored
      @(negedge clk); fv = 0; lv = 1; pix = 8'hC3;
    end
    for (int i = 0; i < 6; i++) send_byte(8'(i));
    hblank(3);
    for (int i = 6; i < 11; i++) send_byte(8'(i));
    end_frame();
    compare_stream("R1");
    if (got_q.size() > 0)
      check(got_q[0].d == 32'h03020100, "R2", "little-endian word", got_q[0].d, 32'h03020100);
    if (got_q.size() > 2)
      check(got_q[2].d == 32'h000a0908 && got_q[2].nb == 11, "R5", "zero-padded tail",
            got_q[2].d, 32'h000a0908);
    check(n_fd == 1, "R5", "frame_done pulses", n_fd, 1);
    check(ovf == 0, "R1", "no overflow", ovf, 0);
  endtask

  // R3, R4, R6: full buffers, alternation, frame end on an empty buffer
  task automatic t_full_buffers();
    do_reset();
    send_line(BUF, 17);
    end_frame();
    check(n_bf == 1, "R3", "buf_full after one buffer", n_bf, 1);
    check(n_fd == 1, "R6", "frame_done on empty tail", n_fd, 1);
    send_line(10, 40); hblank(2); send_line(30, 90);
    end_frame();
    compare_stream("R4");
    check(n_bf == 3, "R3", "buf_full count", n_bf, 3);
    check(n_fd == 2, "R5", "frame_done count", n_fd, 2);
    if (got_q.size() == 14)
      check(got_q[3].last && got_q[3].nb == BUF && got_q[7].ch == 1'b1,
            "R6", "first buffer closes alone, next on ch1", got_q[7].ch, 1);
  endtask

  // R5: frame ending on a word boundary
  task automatic t_aligned_end();
    do_reset();
    send_line(8, 3);
    end_frame();
    compare_stream("R5");
    if (got_q.size() == 2)
      check(got_q[1].last && got_q[1].nb == 8, "R5", "aligned close bytes", got_q[1].nb, 8);
  endtask

  // R7: unreleased channels drop bytes and set sticky overflow
  task automatic t_overflow();
    do_reset();
    auto_rel = 0;
    send_line(40, 5);
    end_frame();
    compare_stream("R7");
    check(ovf == 1, "R7", "overflow set", ovf, 1);
    check(m_ovf == 1, "R7", "model agrees on drop", m_ovf, 1);
    @(negedge clk); rel_man = 2'b01; m_free[0] = 1;
    @(negedge clk); rel_man = 2'b00;
    exp_q.delete(); got_q.delete();
    send_line(8, 77);
    end_frame();
    compare_stream("R7");
    check(ovf == 1, "R7", "overflow stays set", ovf, 1);
    auto_rel = 1;
  endtask

  // R8: backpressure keeps the head word stable
  task automatic t_backpressure();
    do_reset();
    fork
      for (int i = 0; i < 120; i++) begin
        @(negedge clk); ready = (i % 3) != 0;
      end
      begin send_line(20, 11); hblank(4); send_line(17, 200); end_frame(); end
    join
    @(negedge clk); ready = 1;
    compare_stream("R8");
    check(stall_err == 0, "R8", "stall stability errors", stall_err, 0);
  endtask

  // R9: sensor reset output
  task automatic t_sensor();
    do_reset();
    @(negedge clk); req = 1;
    @(negedge clk);
    check(srst_n == 0, "R9", "sensor reset asserted", srst_n, 0);
    req = 0;
    @(negedge clk);
    check(srst_n == 1, "R9", "sensor reset released", srst_n, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_short_frame();
    t_full_buffers();
    t_aligned_end();
    t_overflow();
    t_backpressure();
    t_sensor();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule